// File: doc/BRIEF.md
# Pad Configuration Serial Chain Loader

This block keeps one configuration word per I/O pad and delivers all of them to the pad ring over three wires: a serial clock, a serial data line and a shared active-low reset. The pad cells are daisy-chained. Each cell's shift register feeds the next one from its top bit. Control software writes the words through a small register port, picks a clock divider and issues a start. The block then derives a slow serial clock, shifts out every bit and ends with a load pulse. The load pulse tells every cell to copy its shift register into its output controls.

There is no separate load strobe. The reset line carries both commands, and the level of the serial clock tells them apart. Reset low with the clock high means load. Reset low with the clock low means clear, which returns every cell to its default pad state. The block therefore sequences these two lines so that a load can never look like a clear. A clear is only produced when it is requested explicitly.

Each pad word holds the following controls:
- management enable at bit 0
- output disable at bit 1
- hold at bit 2
- input disable at bit 4
- buffer mode at bit 5
- analog enable, select and polarity at bits 6 to 8
- slew at bit 9
- trip point at bit 10
- a 3-bit drive mode in bits 13:11

A word width below 14 stops elaboration.

Top module: `pad_chain_loader`

## Requirements
- R1: After reset, `busy` is 0, `chain_clk` is 0 and `chain_rst_n` is 1. Every stored pad word equals the default 14'h0802: output disable (bit 1) set, drive mode bits 13:11 = 3'b001, all other bits 0.
- R2: A write with `cfg_wr_en` high stores `cfg_wr_data` as the word of pad `cfg_wr_pad`. The write is ignored while `busy` is high and in the cycle a start or clear is accepted.
- R3: After a load, the chain cell at position k (k = 0 nearest the loader) holds exactly the word stored for pad k. To achieve this, the loader sends pad NUM_PADS-1 first and each word most significant bit first.
- R4: Each half period of `chain_clk` lasts `cfg_div`+1 system cycles. A load produces exactly NUM_PADS×WORD_W rising edges. `chain_data` changes only while `chain_clk` is low.
- R5: After the last rising edge, `chain_clk` stays high. `chain_rst_n` then goes low for two half periods, returns high, and only after that does `chain_clk` fall. `busy` is high for (2×NUM_PADS×WORD_W+3)×(`cfg_div`+1) cycles.
- R6: `cfg_start` and `cfg_clear` are ignored while `busy` is high. If both are asserted together while idle, the start is taken.
- R7: A clear holds `chain_clk` low and drives `chain_rst_n` low for two half periods. This returns every cell to the default word. The stored pad words are not changed. `busy` is high for 3×(`cfg_div`+1) cycles.
- R8: `chain_rst_n` is never low while `chain_clk` is low, except during a requested clear. `chain_clk` never falls while `chain_rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for a pad word |
| cfg_wr_pad | input | PAD_AW | Pad index of the write |
| cfg_wr_data | input | WORD_W | Pad word to store |
| cfg_start | input | 1 | Start a full chain load |
| cfg_clear | input | 1 | Request a chain clear |
| cfg_div | input | DIV_W | Serial half period minus one, in system cycles |
| busy | output | 1 | A load or clear is in progress |
| chain_clk | output | 1 | Serial clock to the pad chain |
| chain_data | output | 1 | Serial data to the first pad cell |
| chain_rst_n | output | 1 | Shared reset; encodes load and clear |

## Verification
The bench contains a model of the pad chain, built from the bench's own sampling of the three chain wires. The loader is driven with several kinds of word sets:
- The untouched reset words.
- Random words at random dividers, which exercise the general case.
- One-hot words at the two ends of a word, such as 14'h0001 and 14'h2000, which expose a bit-order or word-order reversal.
- Alternating 0x1555/0x2AAA patterns, which expose an off-by-one shift.

Each load is also measured for:
- edge count
- busy length
- width of the reset pulse

These measurements separate divider errors from sequencing errors. A start, clear and write issued mid-load, followed by a clear and a reload, show whether commands are ignored while busy. They also show whether a clear touches the stored words.

// File: rtl/pcl_pkg.sv
// Package: shared constants and state encoding for the pad chain loader.
// Assumes pad words are at most 32 bits wide, so the default word fits a 32-bit constant.
package pcl_pkg;

    // Smallest legal word: the 3-bit drive field starts at bit 11.
    localparam int PCL_MIN_WORD_W = 14;

    // Pad word field positions (the pad cells decode these).
    localparam int PCL_B_MGMT   = 0;
    localparam int PCL_B_OUTDIS = 1;
    localparam int PCL_B_DRIVE  = 11;

    // Default word: output disabled, drive mode 3'b001, everything else 0.
    localparam logic [31:0] PCL_DEFAULT_WORD =
        (32'd1 << PCL_B_OUTDIS) | (32'd1 << PCL_B_DRIVE);

    // Sequencer states: shift phases, load pulse, clear pulse.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SH_LO,
        ST_SH_HI,
        ST_LD_P1,
        ST_LD_P2,
        ST_LD_REL,
        ST_CL_LO,
        ST_CL_P1,
        ST_CL_P2
    } pcl_state_e;

endpackage

// File: rtl/pcl_word_bank.sv
// Module: per-pad configuration word storage.
// Holds one register per pad and presents all of them as one flat vector,
// with pad k occupying bits [k*WORD_W +: WORD_W].
// Assumes: lock is high whenever the sequencer may be reading the words.
module pcl_word_bank #(
    parameter int NUM_PADS = 4,
    parameter int WORD_W   = 14,
    parameter int PAD_AW   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lock,
    input  logic                       busy,
    input  logic                       wr_en,
    input  logic [PAD_AW-1:0]          wr_pad,
    input  logic [WORD_W-1:0]          wr_data,
    output logic [NUM_PADS*WORD_W-1:0] words_flat
);
    import pcl_pkg::*;

    localparam logic [WORD_W-1:0] DEF_WORD = WORD_W'(PCL_DEFAULT_WORD);

    for (genvar k = 0; k < NUM_PADS; k++) begin : g_pad
        logic [WORD_W-1:0] word_q;

        // Store a new word for pad k when written and not locked.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= DEF_WORD;
            end else if (wr_en && !lock && (wr_pad == PAD_AW'(k))) begin
                word_q <= wr_data;
            end
        end

        assign words_flat[k*WORD_W +: WORD_W] = word_q;
    end

    // Words must not move while the chain is being shifted.
    AST_WORDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(words_flat)); // R2

endmodule

// File: rtl/pcl_clk_div.sv
// Module: phase tick generator for the serial clock.
// Emits one tick every div_val+1 system cycles while run is high.
// The divider value is captured while idle, so changes during a run have no effect.
module pcl_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    output logic             tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;

    // Capture the divider while idle; hold it during a run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run) begin
            div_q <= div_in;
        end
    end

    // Count system cycles within one serial half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == div_q);

    // The counter never passes the captured limit.
    AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= div_q)); // R4

endmodule

// File: rtl/pcl_seq.sv
// Module: shift, load and clear sequencer for the pad chain.
// Sends the flat word vector from its top bit down to bit 0. The farthest
// pad's word goes first, most significant bit first. It then encodes a load
// as reset-low with the clock high, and a clear as reset-low with the clock low.
// All three chain outputs come straight from flops.
// Assumes: a tick arrives on each phase boundary while busy.
module pcl_seq #(
    parameter int NUM_PADS = 4,
    parameter int WORD_W   = 14
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic                       start,
    input  logic                       clear,
    input  logic [NUM_PADS*WORD_W-1:0] words_flat,
    output logic                       busy,
    output logic                       accept,
    output logic                       chain_clk,
    output logic                       chain_data,
    output logic                       chain_rst_n
);
    import pcl_pkg::*;

    localparam int TOTAL_BITS = NUM_PADS * WORD_W;
    localparam int IDX_W      = $clog2(TOTAL_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL_BITS - 1);

    pcl_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    logic             sclk_q;
    logic             srst_q;
    logic             sdat_q;

    assign busy        = (state_q != ST_IDLE);
    assign accept      = !busy && (start || clear);
    assign chain_clk   = sclk_q;
    assign chain_rst_n = srst_q;
    assign chain_data  = sdat_q;

    // Step the chain sequence on each phase tick; leave idle on a command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            sclk_q  <= 1'b0;
            srst_q  <= 1'b1;
            sdat_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_SH_LO;
                        idx_q   <= LAST_IDX;
                        sdat_q  <= words_flat[LAST_IDX];
                    end else if (clear) begin
                        state_q <= ST_CL_LO;
                    end
                end
                ST_SH_LO: begin
                    if (tick) begin
                        state_q <= ST_SH_HI;
                        sclk_q  <= 1'b1;
                    end
                end
                ST_SH_HI: begin
                    if (tick) begin
                        if (idx_q == '0) begin
                            state_q <= ST_LD_P1;
                            srst_q  <= 1'b0;
                        end else begin
                            state_q <= ST_SH_LO;
                            sclk_q  <= 1'b0;
                            idx_q   <= idx_q - 1'b1;
                            sdat_q  <= words_flat[idx_q - 1'b1];
                        end
                    end
                end
                ST_LD_P1: if (tick) state_q <= ST_LD_P2;
                ST_LD_P2: begin
                    if (tick) begin
                        state_q <= ST_LD_REL;
                        srst_q  <= 1'b1;
                    end
                end
                ST_LD_REL: begin
                    if (tick) begin
                        state_q <= ST_IDLE;
                        sclk_q  <= 1'b0;
                    end
                end
                ST_CL_LO: begin
                    if (tick) begin
                        state_q <= ST_CL_P1;
                        srst_q  <= 1'b0;
                    end
                end
                ST_CL_P1: if (tick) state_q <= ST_CL_P2;
                ST_CL_P2: begin
                    if (tick) begin
                        state_q <= ST_IDLE;
                        srst_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Data may only move while the serial clock is low.
    AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_q && $past(sclk_q)) |-> $stable(sdat_q)); // R4

    // Reset low with the clock low only inside a requested clear.
    AST_NO_FALSE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst_q && !sclk_q) |-> (state_q == ST_CL_P1 || state_q == ST_CL_P2)); // R8

    // The clock never falls while the reset line is held low.
    AST_CLK_FALL_RST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_q) |-> srst_q); // R5

    // A load pulse begins only once the clock is already high.
    AST_LOAD_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(srst_q) && state_q == ST_LD_P1) |-> (sclk_q && $past(sclk_q))); // R5

    // A command arriving mid-run leaves the sequence running.
    AST_CMD_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (start || clear) && !tick) |=> busy); // R6

endmodule

// File: rtl/pad_chain_loader.sv
// Module: top of the pad configuration serial chain loader.
// Joins the word bank, the phase divider and the sequencer.
// Assumes WORD_W >= 14 so the drive field fits; otherwise elaboration stops.
module pad_chain_loader #(
    parameter int NUM_PADS = 4,
    parameter int WORD_W   = 14,
    parameter int DIV_W    = 8,
    parameter int PAD_AW   = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [PAD_AW-1:0] cfg_wr_pad,
    input  logic [WORD_W-1:0] cfg_wr_data,
    input  logic              cfg_start,
    input  logic              cfg_clear,
    input  logic [DIV_W-1:0]  cfg_div,
    output logic              busy,
    output logic              chain_clk,
    output logic              chain_data,
    output logic              chain_rst_n
);
    import pcl_pkg::*;

    if (WORD_W < PCL_MIN_WORD_W) begin : g_width_check
        $error("pad_chain_loader: WORD_W too small for drive field");
    end

    logic [NUM_PADS*WORD_W-1:0] words_flat;
    logic                       tick;
    logic                       accept;
    logic                       busy_int;

    pcl_word_bank #(
        .NUM_PADS (NUM_PADS),
        .WORD_W   (WORD_W),
        .PAD_AW   (PAD_AW)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock       (busy_int || accept),
        .busy       (busy_int),
        .wr_en      (cfg_wr_en),
        .wr_pad     (cfg_wr_pad),
        .wr_data    (cfg_wr_data),
        .words_flat (words_flat)
    );

    pcl_clk_div #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy_int),
        .div_in (cfg_div),
        .tick   (tick)
    );

    pcl_seq #(
        .NUM_PADS (NUM_PADS),
        .WORD_W   (WORD_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .start       (cfg_start),
        .clear       (cfg_clear),
        .words_flat  (words_flat),
        .busy        (busy_int),
        .accept      (accept),
        .chain_clk   (chain_clk),
        .chain_data  (chain_data),
        .chain_rst_n (chain_rst_n)
    );

    assign busy = busy_int;

endmodule

// File: tb/tb_pad_chain_loader.sv
// Bench: models a chain of pad cells on the three chain wires and compares
// their loaded words, edge counts and pulse widths with values computed here.
module tb_pad_chain_loader;
    localparam int N     = 4;
    localparam int W     = 14;
    localparam int DW    = 8;
    localparam int AW    = 2;
    localparam logic [W-1:0] DEF = 14'h0802;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic [AW-1:0] cfg_wr_pad = '0;
    logic [W-1:0]  cfg_wr_data = '0;
    logic          cfg_start = 1'b0;
    logic          cfg_clear = 1'b0;
    logic [DW-1:0] cfg_div = '0;
    logic          busy, chain_clk, chain_data, chain_rst_n;

    always #10 clk = ~clk;

    pad_chain_loader #(.NUM_PADS(N), .WORD_W(W), .DIV_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_pad(cfg_wr_pad),
        .cfg_wr_data(cfg_wr_data), .cfg_start(cfg_start), .cfg_clear(cfg_clear),
        .cfg_div(cfg_div), .busy(busy), .chain_clk(chain_clk),
        .chain_data(chain_data), .chain_rst_n(chain_rst_n)
    );

    // Chain model and wire monitors (cumulative counters only).
    logic [W-1:0] cell_sh [N];
    logic [W-1:0] cell_out [N];
    logic [W-1:0] exp_w [N];
    int  edge_cnt = 0, busy_cnt = 0, data_bad = 0, lowlow_bad = 0;
    int  low_run = 0, last_low = 0;
    logic prev_clk = 1'b0, prev_dat = 1'b0, in_clear = 1'b0;
    int  n_chk = 0, n_fail = 0;
    bit  done = 1'b0;

    initial begin
        for (int k = 0; k < N; k++) begin
            cell_sh[k] = '0;
            cell_out[k] = '0;
            exp_w[k] = DEF;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (chain_clk && !prev_clk) begin
                edge_cnt++;
                for (int k = N - 1; k > 0; k--)
                    cell_sh[k] = {cell_sh[k][W-2:0], cell_sh[k-1][W-1]};
                cell_sh[0] = {cell_sh[0][W-2:0], chain_data};
            end
            if (chain_clk && prev_clk && chain_data != prev_dat) data_bad++;
            if (!chain_rst_n) begin
                low_run++;
                if (chain_clk) begin
                    for (int k = 0; k < N; k++) cell_out[k] = cell_sh[k];
                end else begin
                    if (!in_clear) lowlow_bad++;
                    for (int k = 0; k < N; k++) begin
                        cell_sh[k] = '0;
                        cell_out[k] = DEF;
                    end
                end
            end else if (low_run != 0) begin
                last_low = low_run;
                low_run = 0;
            end
            if (busy) busy_cnt++;
            prev_clk = chain_clk;
            prev_dat = chain_data;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_word(input int pad, input logic [W-1:0] val);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_pad = AW'(pad); cfg_wr_data = val;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        exp_w[pad] = val;
    endtask

    task automatic wait_idle();
        int t = 0;
        while (busy && t < 20000) begin
            @(negedge clk);
            t++;
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    // Full load at divider d with all per-load checks.
    task automatic do_load(input int d, input string tag);
        int e0, b0, dbad0, ll0;
        cfg_div = DW'(d);
        e0 = edge_cnt; b0 = busy_cnt; dbad0 = data_bad; ll0 = lowlow_bad;
        @(negedge clk);
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        wait_idle();
        for (int k = 0; k < N; k++)
            check(cell_out[k] === exp_w[k], {"R3 ", tag}, int'(cell_out[k]), int'(exp_w[k]));
        check(edge_cnt - e0 == N * W, "R4 edge count", edge_cnt - e0, N * W);
        check(data_bad == dbad0, "R4 data moved with clock high", data_bad - dbad0, 0);
        check(busy_cnt - b0 == (2 * N * W + 3) * (d + 1), "R5 busy length",
              busy_cnt - b0, (2 * N * W + 3) * (d + 1));
        check(last_low == 2 * (d + 1), "R5 load pulse width", last_low, 2 * (d + 1));
        check(lowlow_bad == ll0, "R8 reset low with clock low", lowlow_bad - ll0, 0);
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports.
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        check(chain_clk == 1'b0, "R1 chain_clk", int'(chain_clk), 0);
        check(chain_rst_n == 1'b1, "R1 chain_rst_n", int'(chain_rst_n), 1);
        // R1: untouched words load as the default.
        do_load(0, "R1 default words");

        // R3: one-hot ends and alternating patterns.
        write_word(0, 14'h0001); write_word(1, 14'h2000);
        write_word(2, 14'h1555); write_word(3, 14'h2AAA);
        do_load(1, "asymmetric words");

        // Random words at random dividers.
        for (int it = 0; it < 6; it++) begin
            for (int k = 0; k < N; k++) write_word(k, W'($urandom()));
            do_load(int'($urandom_range(0, 3)), "random words");
        end

        // R6 and R2: start, clear and write issued mid-load are ignored.
        begin
            int e0;
            e0 = edge_cnt;
            cfg_div = DW'(1);
            @(negedge clk); cfg_start = 1'b1;
            @(negedge clk); cfg_start = 1'b0;
            repeat (20) @(negedge clk);
            cfg_start = 1'b1; cfg_clear = 1'b1;
            cfg_wr_en = 1'b1; cfg_wr_pad = 2'd2; cfg_wr_data = 14'h3FFF;
            @(negedge clk);
            cfg_start = 1'b0; cfg_clear = 1'b0; cfg_wr_en = 1'b0;
            wait_idle();
            check(edge_cnt - e0 == N * W, "R6 start ignored while busy", edge_cnt - e0, N * W);
            check(cell_out[2] === exp_w[2], "R6 clear ignored while busy",
                  int'(cell_out[2]), int'(exp_w[2]));
            do_load(0, "R2 write ignored while busy");
        end

        // R6: start and clear together while idle, start wins.
        begin
            int e0;
            e0 = edge_cnt;
            @(negedge clk); cfg_start = 1'b1; cfg_clear = 1'b1;
            @(negedge clk); cfg_start = 1'b0; cfg_clear = 1'b0;
            wait_idle();
            check(edge_cnt - e0 == N * W, "R6 start beats clear", edge_cnt - e0, N * W);
        end

        // R7: clear returns cells to default and leaves the stored words.
        begin
            int b0, e0;
            cfg_div = DW'(2);
            b0 = busy_cnt; e0 = edge_cnt;
            in_clear = 1'b1;
            @(negedge clk); cfg_clear = 1'b1;
            @(negedge clk); cfg_clear = 1'b0;
            wait_idle();
            in_clear = 1'b0;
            for (int k = 0; k < N; k++)
                check(cell_out[k] === DEF, "R7 cell default after clear", int'(cell_out[k]), int'(DEF));
            check(busy_cnt - b0 == 3 * 3, "R7 clear busy length", busy_cnt - b0, 9);
            check(last_low == 2 * 3, "R7 clear pulse width", last_low, 6);
            check(edge_cnt == e0, "R7 no clock edge in clear", edge_cnt - e0, 0);
            do_load(0, "R7 words kept after clear");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule